// File: doc/BRIEF.md
# Serial-Port Byte Memory Slave

This block models a small non-volatile byte memory that sits behind a four-wire serial port (clock, select, data in, data out), with a pause input and a write-block input. It holds 512 bytes. A host selects the block, shifts in an instruction byte, an address and data, and gets read data or status back on the output line. Writes are collected into a one-page staging buffer. When select is released they are committed into the array during a self-timed busy period.

The serial pins are sampled by the block's own system clock, and the clock edges are found by comparing each sample with the one before it. The host can idle its serial clock either low or high. The output has a separate drive-enable, so a pad outside the block can float the line while the block is deselected or paused.

Top module: `spi_byte_mem`

## Requirements
- R1: `so_oe` is low whenever `cs_n` is high or `hold_n` is low, and high while `cs_n` is low and `hold_n` is high.
- R2: Input bits are taken most significant bit first on rising `sck` edges, starting at the first rising edge after `cs_n` falls. The instruction codes are 0x06 (set write latch), 0x04 (clear write latch), 0x05 (read status), 0x01 (write status), 0x03 (read) and 0x02 (write). For read and write, bit 3 of the instruction byte is address bit 8 and the next byte gives address bits 7..0.
- R3: Read data leaves MSB first on `so`. It changes on falling `sck` edges, and the first bit appears at the first falling edge after the address byte has been taken in.
- R4: A host that idles `sck` high gets the same results as one that idles it low.
- R5: While `hold_n` is low, `sck` edges are ignored. Bits already taken in are kept, and shifting resumes at the same bit position when `hold_n` returns high.
- R6: While `wp_n` is low, write and write-status instructions are refused and the write latch is cleared. Status reads, data reads and the latch-setting instruction still work.
- R7: Once a write cycle has started, it runs its full `TWR_CYCLES` clocks and commits its data, whatever `wp_n` or the write latch does afterwards.
- R8: A write starts only when the write latch is set, at least one data byte was sent, and `cs_n` rises on a byte boundary. A write that does not start clears the latch. While a cycle runs, status bit 0 is 1, and the latch is cleared when the cycle ends.
- R9: In a write, the data bytes after the first land at following addresses, wrapping within the 16-byte page of the start address.
- R10: A read returns consecutive bytes and wraps from address 511 to address 0.
- R11: The status byte has bit 0 = busy, bit 1 = write latch, bits 3:2 = protect field, and all other bits 0. Write-status (with the latch set) loads bits 3:2 through a timed cycle. A status read repeats the status byte for as long as clocks continue.
- R12: The protect field blocks writes to part of the array: 01 blocks addresses 384..511, 10 blocks 256..511, 11 blocks the whole array, and 00 blocks nothing. A blocked write is refused as in R8.
- R13: While busy, every instruction except status read is ignored, and a read returns all-zero bits.
- R14: After reset the status byte is 0x00 and every array byte reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the serial clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low select |
| mosi | input | 1 | Serial data into the block |
| hold_n | input | 1 | Active-low pause of the serial link |
| wp_n | input | 1 | Active-low write block |
| so | output | 1 | Serial data out of the block |
| so_oe | output | 1 | Drive enable for `so` |

## Verification
The assertions assume that `sck`, `cs_n`, `mosi` and `hold_n` change relative to `clk`, with each serial clock phase lasting at least four system clocks. They also assume that `hold_n` only changes while `sck` is at its idle level. The bench drives every pin on the falling edge of `clk` and holds each `sck` level for four clocks. It asserts and releases pause only while `sck` is low, and it toggles `cs_n` only while `sck` is at the level of the mode in use. The bench lengthens the write cycle so that a full read transaction fits inside one busy period.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;
   localparam int BYTE_W = 8;

   localparam logic [7:0] OP_SET_LATCH = 8'h06;
   localparam logic [7:0] OP_CLR_LATCH = 8'h04;
   localparam logic [7:0] OP_GET_STAT  = 8'h05;
   localparam logic [7:0] OP_PUT_STAT  = 8'h01;
   localparam logic [7:0] OP_READ      = 8'h03;
   localparam logic [7:0] OP_WRITE     = 8'h02;
   localparam logic [7:0] OP_HIBIT_MSK = 8'hF7;

   typedef enum logic [2:0] {
      K_NONE, K_SET_LATCH, K_CLR_LATCH, K_GET_STAT, K_PUT_STAT, K_READ, K_WRITE
   } op_kind_e;

   typedef enum logic [2:0] {
      S_OPCODE, S_ADDR, S_WDATA, S_RDATA, S_STAT_OUT, S_STAT_IN, S_SKIP
   } cmd_state_e;

   function automatic op_kind_e decode_op(input logic [7:0] b);
      if (b == OP_SET_LATCH)                    return K_SET_LATCH;
      if (b == OP_CLR_LATCH)                    return K_CLR_LATCH;
      if (b == OP_GET_STAT)                     return K_GET_STAT;
      if (b == OP_PUT_STAT)                     return K_PUT_STAT;
      if ((b & OP_HIBIT_MSK) == OP_READ)        return K_READ;
      if ((b & OP_HIBIT_MSK) == OP_WRITE)       return K_WRITE;
      return K_NONE;
   endfunction
endpackage

// File: rtl/spi_ee_link.sv
module spi_ee_link
   import spi_ee_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sck,
   input  logic              cs_n,
   input  logic              hold_n,
   input  logic              mosi,
   input  logic              tx_en,
   input  logic [BYTE_W-1:0] tx_byte,
   output logic [BYTE_W-1:0] rx_byte,
   output logic              rx_done,
   output logic              tx_take,
   output logic              aligned,
   output logic              cs_rise,
   output logic              so_d,
   output logic              so_oe
);
   localparam int CNT_W = $clog2(BYTE_W);

   logic              sck_q, cs_q;
   logic [CNT_W-1:0]  bitcnt;
   logic [BYTE_W-2:0] rx_sh;
   logic [BYTE_W-1:0] tx_sh;
   logic              active, rise, fall;

   assign active  = !cs_n && hold_n;
   assign rise    = active && sck && !sck_q;
   assign fall    = active && !sck && sck_q;
   assign rx_done = rise && (bitcnt == CNT_W'(BYTE_W - 1));
   assign rx_byte = {rx_sh, mosi};
   assign tx_take = fall && (bitcnt == '0) && tx_en;
   assign aligned = (bitcnt == '0);
   assign cs_rise = cs_n && !cs_q;
   assign so_d    = tx_sh[BYTE_W-1];
   assign so_oe   = active;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_q  <= 1'b0;
         cs_q   <= 1'b1;
         bitcnt <= '0;
         rx_sh  <= '0;
         tx_sh  <= '0;
      end else begin
         sck_q <= sck;
         cs_q  <= cs_n;
         if (cs_n) begin
            bitcnt <= '0;
            tx_sh  <= '0;
         end else begin
            if (rise) begin
               rx_sh  <= {rx_sh[BYTE_W-3:0], mosi};
               bitcnt <= bitcnt + 1'b1;
            end
            if (tx_take)
               tx_sh <= tx_byte;
            else if (fall)
               tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
         end
      end
   end

   // R5: a paused link keeps its bit position and partial byte
   a_r5_hold_keeps_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold_n && !cs_n) |=> ($stable(bitcnt) && $stable(rx_sh)));

   // R3: output only moves on a falling serial edge
   a_r3_out_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && !(hold_n && !sck && sck_q)) |=> $stable(tx_sh));
endmodule

// File: rtl/spi_ee_array.sv
module spi_ee_array
   import spi_ee_pkg::*;
#(
   parameter int ADDR_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [BYTE_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [BYTE_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [BYTE_W-1:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
      end else if (we) begin
         mem[waddr] <= wdata;
      end
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/spi_ee_wcycle.sv
module spi_ee_wcycle
   import spi_ee_pkg::*;
#(
   parameter int ADDR_W     = 9,
   parameter int PAGE_W     = 4,
   parameter int TWR_CYCLES = 64
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               buf_clr,
   input  logic               buf_we,
   input  logic [PAGE_W-1:0]  buf_col,
   input  logic [BYTE_W-1:0]  buf_data,
   input  logic               start,
   input  logic [ADDR_W-PAGE_W-1:0] start_row,
   output logic               busy,
   output logic               done,
   output logic               mem_we,
   output logic [ADDR_W-1:0]  mem_addr,
   output logic [BYTE_W-1:0]  mem_wdata
);
   localparam int PAGE  = 1 << PAGE_W;
   localparam int ROW_W = ADDR_W - PAGE_W;
   localparam int CW    = $clog2(TWR_CYCLES + 1);

   if (TWR_CYCLES < PAGE) begin : g_bad_twr
      $error("TWR_CYCLES must cover one commit slot per page byte");
   end

   logic [BYTE_W-1:0] pbuf [PAGE];
   logic [PAGE-1:0]   valid;
   logic [CW-1:0]     cnt;
   logic [ROW_W-1:0]  row;
   logic [PAGE_W-1:0] idx;
   logic              in_win;

   assign idx       = cnt[PAGE_W-1:0];
   assign in_win    = (cnt < CW'(PAGE));
   assign done      = busy && (cnt == CW'(TWR_CYCLES - 1));
   assign mem_we    = busy && in_win && valid[idx];
   assign mem_addr  = {row, idx};
   assign mem_wdata = pbuf[idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid <= '0;
         for (int i = 0; i < PAGE; i++) pbuf[i] <= '0;
      end else if (buf_clr) begin
         valid <= '0;
      end else if (buf_we) begin
         pbuf[buf_col]  <= buf_data;
         valid[buf_col] <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
         row  <= '0;
      end else if (start && !busy) begin
         busy <= 1'b1;
         cnt  <= '0;
         row  <= start_row;
      end else if (busy) begin
         cnt <= cnt + 1'b1;
         if (done) busy <= 1'b0;
      end
   end

   // R7: a started cycle is never cut short
   a_r7_cycle_runs_out: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cnt != CW'(TWR_CYCLES - 1)) |=> busy);

   // R9: commits stay inside the page latched at start
   a_r9_row_fixed: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(row));
endmodule

// File: rtl/spi_ee_cmd.sv
module spi_ee_cmd
   import spi_ee_pkg::*;
#(
   parameter int ADDR_W = 9,
   parameter int PAGE_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cs_n,
   input  logic               wp_n,
   input  logic               rx_done,
   input  logic [BYTE_W-1:0]  rx_byte,
   input  logic               aligned,
   input  logic               cs_rise,
   input  logic               tx_take,
   output logic               tx_en,
   output logic [BYTE_W-1:0]  tx_byte,
   input  logic [BYTE_W-1:0]  mem_rdata,
   output logic [ADDR_W-1:0]  rd_addr,
   output logic               buf_clr,
   output logic               buf_we,
   output logic [PAGE_W-1:0]  buf_col,
   output logic [BYTE_W-1:0]  buf_data,
   output logic               start,
   output logic [ADDR_W-PAGE_W-1:0] start_row,
   input  logic               busy,
   input  logic               done
);
   if (ADDR_W < BYTE_W || ADDR_W > BYTE_W + 1) begin : g_bad_aw
      $error("ADDR_W must be 8 or 9: one address byte plus an optional opcode bit");
   end
   if (ADDR_W - PAGE_W < 2) begin : g_bad_page
      $error("protect quarters need at least two row bits");
   end

   cmd_state_e        st;
   op_kind_e          kind, k_new;
   logic [ADDR_W-1:0] addr, addr_load;
   logic [PAGE_W-1:0] col;
   logic [1:0]        nb, prot_f, prot_new;
   logic              wel, a_hi, blocked, wr_go, sr_go;

   if (ADDR_W > BYTE_W) begin : g_hibit
      assign addr_load = {a_hi, rx_byte};
   end else begin : g_nohibit
      assign addr_load = rx_byte[ADDR_W-1:0];
   end

   always_comb begin
      unique case (prot_f)
         2'b00:   blocked = 1'b0;
         2'b01:   blocked = &addr[ADDR_W-1:ADDR_W-2];
         2'b10:   blocked = addr[ADDR_W-1];
         default: blocked = 1'b1;
      endcase
   end

   assign k_new     = decode_op(rx_byte);
   assign wr_go     = (kind == K_WRITE) && (nb == 2'd3) && aligned && wel && wp_n && !blocked;
   assign sr_go     = (kind == K_PUT_STAT) && (nb == 2'd2) && aligned && wel && wp_n;
   assign start     = cs_rise && !busy && (wr_go || sr_go);
   assign start_row = addr[ADDR_W-1:PAGE_W];
   assign buf_clr   = rx_done && (st == S_OPCODE) && !busy
                      && (k_new == K_WRITE || k_new == K_PUT_STAT);
   assign buf_we    = rx_done && (st == S_WDATA);
   assign buf_col   = col;
   assign buf_data  = rx_byte;
   assign tx_en     = (st == S_RDATA) || (st == S_STAT_OUT);
   assign tx_byte   = (st == S_STAT_OUT) ? {4'b0, prot_f, wel, busy} : mem_rdata;
   assign rd_addr   = addr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= S_OPCODE;
         kind     <= K_NONE;
         addr     <= '0;
         col      <= '0;
         nb       <= '0;
         wel      <= 1'b0;
         a_hi     <= 1'b0;
         prot_f   <= '0;
         prot_new <= '0;
      end else begin
         if (done) wel <= 1'b0;
         if (cs_n) begin
            st   <= S_OPCODE;
            nb   <= '0;
            kind <= K_NONE;
            if (cs_rise) begin
               unique case (kind)
                  K_SET_LATCH: if (nb == 2'd1 && aligned) wel <= 1'b1;
                  K_CLR_LATCH: if (nb == 2'd1 && aligned) wel <= 1'b0;
                  K_WRITE:     if (!wr_go) wel <= 1'b0;
                  K_PUT_STAT:  if (sr_go) prot_f <= prot_new; else wel <= 1'b0;
                  default: ;
               endcase
            end
         end else begin
            if (rx_done && nb != 2'd3) nb <= nb + 1'b1;
            if (rx_done) begin
               unique case (st)
                  S_OPCODE: begin
                     a_hi <= rx_byte[3];
                     if (busy) begin
                        kind <= K_NONE;
                        st   <= (k_new == K_GET_STAT) ? S_STAT_OUT : S_SKIP;
                     end else begin
                        kind <= k_new;
                        unique case (k_new)
                           K_GET_STAT:       st <= S_STAT_OUT;
                           K_PUT_STAT:       st <= S_STAT_IN;
                           K_READ, K_WRITE:  st <= S_ADDR;
                           default:          st <= S_SKIP;
                        endcase
                     end
                  end
                  S_ADDR: begin
                     addr <= addr_load;
                     col  <= rx_byte[PAGE_W-1:0];
                     st   <= (kind == K_READ) ? S_RDATA : S_WDATA;
                  end
                  S_WDATA:   col <= col + 1'b1;
                  S_STAT_IN: prot_new <= rx_byte[3:2];
                  default: ;
               endcase
            end
            if (tx_take && st == S_RDATA) addr <= addr + 1'b1;
         end
      end
   end

   // R6: a cycle only begins when the block input allowed it
   a_r6_wp_gates_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(wp_n));

   // R8: the write latch is clear once a cycle has finished
   a_r8_latch_clear_after: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> !wel);

   // R13: nothing but status is decoded while busy
   a_r13_busy_decode: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && !cs_n) |-> (kind == K_NONE));
endmodule

// File: rtl/spi_byte_mem.sv
module spi_byte_mem
   import spi_ee_pkg::*;
#(
   parameter int ADDR_W     = 9,
   parameter int PAGE_W     = 4,
   parameter int TWR_CYCLES = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sck,
   input  logic cs_n,
   input  logic mosi,
   input  logic hold_n,
   input  logic wp_n,
   output logic so,
   output logic so_oe
);
   localparam int ROW_W = ADDR_W - PAGE_W;

   logic [BYTE_W-1:0] rx_byte, tx_byte, mem_rdata, buf_data, mem_wdata;
   logic              rx_done, tx_take, aligned, cs_rise, tx_en;
   logic [ADDR_W-1:0] rd_addr, mem_addr;
   logic              buf_clr, buf_we, start, busy, done, mem_we;
   logic [PAGE_W-1:0] buf_col;
   logic [ROW_W-1:0]  start_row;

   spi_ee_link u_link (
      .clk, .rst_n, .sck, .cs_n, .hold_n, .mosi,
      .tx_en, .tx_byte, .rx_byte, .rx_done, .tx_take, .aligned, .cs_rise,
      .so_d(so), .so_oe
   );

   spi_ee_cmd #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_cmd (
      .clk, .rst_n, .cs_n, .wp_n, .rx_done, .rx_byte, .aligned, .cs_rise,
      .tx_take, .tx_en, .tx_byte, .mem_rdata, .rd_addr, .buf_clr, .buf_we,
      .buf_col, .buf_data, .start, .start_row, .busy, .done
   );

   spi_ee_wcycle #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .TWR_CYCLES(TWR_CYCLES)) u_wcyc (
      .clk, .rst_n, .buf_clr, .buf_we, .buf_col, .buf_data, .start, .start_row,
      .busy, .done, .mem_we, .mem_addr, .mem_wdata
   );

   spi_ee_array #(.ADDR_W(ADDR_W)) u_mem (
      .clk, .rst_n, .we(mem_we), .waddr(mem_addr), .wdata(mem_wdata),
      .raddr(rd_addr), .rdata(mem_rdata)
   );

   // R1: output drive follows select and pause
   a_r1_float_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n || !hold_n) |-> !so_oe);
endmodule

// File: tb/spi_byte_mem_bench.sv
`timescale 1ns/1ps
module spi_byte_mem_bench;
   localparam int HP = 80;

   logic clk = 1'b0, rst_n = 1'b0;
   logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0, hold_n = 1'b1, wp_n = 1'b1;
   logic so, so_oe;
   logic m3 = 1'b0;
   int   n_chk = 0, n_bad = 0;

   always #10 clk = ~clk;

   spi_byte_mem #(.TWR_CYCLES(600)) u_spi_byte_mem (
      .clk, .rst_n, .sck, .cs_n, .mosi, .hold_n, .wp_n, .so, .so_oe
   );

   task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %02h expected %02h", req, got, exp);
      end
   endtask

   task automatic xbits(input int n, input logic [7:0] o, output logic [7:0] i);
      i = '0;
      for (int b = 7; b > 7 - n; b--) begin
         if (m3) sck = 1'b0;
         mosi = o[b];
         #HP;
         i[b] = so;
         sck = 1'b1;
         #HP;
         if (!m3) sck = 1'b0;
      end
   endtask

   task automatic xbyte(input logic [7:0] o, output logic [7:0] i);
      xbits(8, o, i);
   endtask

   task automatic sel();   cs_n = 1'b0; #HP; endtask
   task automatic desel(); #HP; cs_n = 1'b1; #(2*HP); endtask

   task automatic cmd1(input logic [7:0] op);
      logic [7:0] d;
      sel(); xbyte(op, d); desel();
   endtask

   task automatic rdsr(output logic [7:0] s);
      logic [7:0] d;
      sel(); xbyte(8'h05, d); xbyte(8'h00, s); desel();
   endtask

   task automatic wr(input logic [8:0] a, input int n,
                     input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2);
      logic [7:0] d;
      sel();
      xbyte(8'h02 | {4'b0, a[8], 3'b0}, d);
      xbyte(a[7:0], d);
      xbyte(b0, d);
      if (n > 1) xbyte(b1, d);
      if (n > 2) xbyte(b2, d);
      desel();
   endtask

   task automatic rd(input logic [8:0] a, output logic [7:0] r0, output logic [7:0] r1);
      logic [7:0] d;
      sel();
      xbyte(8'h03 | {4'b0, a[8], 3'b0}, d);
      xbyte(a[7:0], d);
      xbyte(8'h00, r0);
      xbyte(8'h00, r1);
      desel();
   endtask

   task automatic wait_idle(input string req);
      logic [7:0] s;
      s = 8'h01;
      for (int k = 0; k < 20 && s[0]; k++) rdsr(s);
      chk(req, {7'b0, s[0]}, 8'h00);
   endtask

   task automatic t_reset();
      logic [7:0] s, a, b;
      chk("R1 deselected drive", {7'b0, so_oe}, 8'h00);
      rdsr(s);  chk("R14 status after reset", s, 8'h00);
      rd(9'h1A3, a, b);
      chk("R14 array erased", a, 8'hFF);
      chk("R14 array erased next", b, 8'hFF);
   endtask

   task automatic t_latch();
      logic [7:0] s;
      cmd1(8'h06); rdsr(s); chk("R11 latch set", s, 8'h02);
      cmd1(8'h04); rdsr(s); chk("R11 latch cleared", s, 8'h00);
   endtask

   task automatic t_byte_write();
      logic [7:0] s, a, b;
      cmd1(8'h06);
      wr(9'h005, 1, 8'hA5, 8'h00, 8'h00);
      rdsr(s); chk("R8 busy and latch during cycle", s, 8'h03);
      wait_idle("R8 cycle ends");
      rdsr(s); chk("R8 latch cleared at end", s, 8'h00);
      rd(9'h005, a, b);
      chk("R2 R3 byte write readback", a, 8'hA5);
      chk("R3 neighbour untouched", b, 8'hFF);
   endtask

   task automatic t_page_wrap();
      logic [7:0] a, b;
      cmd1(8'h06);
      wr(9'h11E, 3, 8'h11, 8'h22, 8'h33);
      wait_idle("R9 cycle ends");
      rd(9'h11E, a, b);
      chk("R9 page byte 0x11E", a, 8'h11);
      chk("R9 page byte 0x11F", b, 8'h22);
      rd(9'h110, a, b);
      chk("R9 wrapped into 0x110", a, 8'h33);
      chk("R9 0x111 untouched", b, 8'hFF);
   endtask

   task automatic t_seq_wrap();
      logic [7:0] a, b;
      cmd1(8'h06); wr(9'h1FF, 1, 8'h77, 8'h00, 8'h00); wait_idle("R10 cycle a");
      cmd1(8'h06); wr(9'h000, 1, 8'h88, 8'h00, 8'h00); wait_idle("R10 cycle b");
      rd(9'h1FF, a, b);
      chk("R10 read at 511", a, 8'h77);
      chk("R10 wrap to 0", b, 8'h88);
   endtask

   task automatic t_wp_refuse();
      logic [7:0] s, a, b;
      wp_n = 1'b0;
      cmd1(8'h06); rdsr(s); chk("R6 latch set under block", s, 8'h02);
      wr(9'h040, 1, 8'h5A, 8'h00, 8'h00);
      rdsr(s); chk("R6 write refused, latch cleared", s, 8'h00);
      rd(9'h040, a, b); chk("R6 array unchanged", a, 8'hFF);
      wp_n = 1'b1;
   endtask

   task automatic t_no_abort();
      logic [7:0] s, a, b;
      cmd1(8'h06);
      wr(9'h041, 1, 8'h3C, 8'h00, 8'h00);
      wp_n = 1'b0;
      cmd1(8'h04);
      rdsr(s); chk("R7 still busy", {7'b0, s[0]}, 8'h01);
      wait_idle("R7 cycle ends");
      wp_n = 1'b1;
      rd(9'h041, a, b); chk("R7 data committed", a, 8'h3C);
   endtask

   task automatic t_hold();
      logic [7:0] d, a, b;
      cmd1(8'h06);
      sel(); xbyte(8'h02, d); xbyte(8'h60, d);
      xbits(4, 8'hC0, d);
      hold_n = 1'b0;
      #HP;
      chk("R1 paused drive", {7'b0, so_oe}, 8'h00);
      for (int k = 0; k < 3; k++) begin
         mosi = k[0]; sck = 1'b1; #HP; sck = 1'b0; #HP;
      end
      hold_n = 1'b1;
      #HP;
      chk("R1 selected drive", {7'b0, so_oe}, 8'h01);
      xbits(4, 8'h30, d);
      desel();
      wait_idle("R5 cycle ends");
      rd(9'h060, a, b); chk("R5 paused byte intact", a, 8'hC3);
   endtask

   task automatic t_mode3();
      logic [7:0] s, a, b;
      m3 = 1'b1; sck = 1'b1; #(2*HP);
      rd(9'h11E, a, b);
      chk("R4 idle-high read", a, 8'h11);
      chk("R4 idle-high second byte", b, 8'h22);
      cmd1(8'h06); rdsr(s); chk("R4 idle-high latch", s, 8'h02);
      cmd1(8'h04);
      m3 = 1'b0; sck = 1'b0; #(2*HP);
   endtask

   task automatic t_misaligned();
      logic [7:0] d, s, a, b;
      cmd1(8'h06);
      sel(); xbyte(8'h02, d); xbyte(8'h30, d); xbyte(8'h99, d); xbits(3, 8'hE0, d); desel();
      rdsr(s); chk("R8 partial byte refused", s, 8'h00);
      rd(9'h030, a, b); chk("R8 array unchanged", a, 8'hFF);
      cmd1(8'h06);
      sel(); xbyte(8'h02, d); xbyte(8'h31, d); desel();
      rdsr(s); chk("R8 no data byte refused", s, 8'h00);
   endtask

   task automatic t_busy_ignore();
      logic [7:0] a, b, s;
      cmd1(8'h06);
      wr(9'h070, 1, 8'h66, 8'h00, 8'h00);
      rd(9'h005, a, b); chk("R13 read while busy", a, 8'h00);
      wait_idle("R13 cycle ends");
      rdsr(s); chk("R13 status after", s, 8'h00);
      rd(9'h070, a, b); chk("R13 write landed", a, 8'h66);
   endtask

   task automatic t_protect();
      logic [7:0] s, a, b, d;
      cmd1(8'h06);
      sel(); xbyte(8'h01, d); xbyte(8'h04, d); desel();
      wait_idle("R11 status cycle ends");
      sel(); xbyte(8'h05, d); xbyte(8'h00, s); xbyte(8'h00, a); desel();
      chk("R11 protect field loaded", s, 8'h04);
      chk("R11 status repeats", a, 8'h04);
      cmd1(8'h06); wr(9'h1F0, 1, 8'h12, 8'h00, 8'h00);
      rdsr(s); chk("R12 top quarter refused", s, 8'h04);
      rd(9'h1F0, a, b); chk("R12 top quarter unchanged", a, 8'hFF);
      cmd1(8'h06); wr(9'h100, 1, 8'h34, 8'h00, 8'h00);
      wait_idle("R12 cycle ends");
      rd(9'h100, a, b); chk("R12 lower area written", a, 8'h34);
      cmd1(8'h06);
      sel(); xbyte(8'h01, d); xbyte(8'h00, d); desel();
      wait_idle("R11 clear cycle ends");
      rdsr(s); chk("R11 protect cleared", s, 8'h00);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_latch();
      t_byte_write();
      t_page_wrap();
      t_seq_wrap();
      t_wp_refuse();
      t_no_abort();
      t_hold();
      t_mode3();
      t_misaligned();
      t_busy_ignore();
      t_protect();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 20);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule